// File: doc/BRIEF.md
# Three-Port Latched Bus Exchanger

The exchanger moves a 9-bit word between three bidirectional ports, A, B and C. A single source port is chosen by two select inputs. Its word is then delivered to one or both of the remaining ports, according to three output-enable inputs. Each pad is modelled as a separate input bus, output bus and output-enable signal.

Four direction latches carry the data: A toward C, B toward C, C toward A and C toward B. Traffic between A and B passes through the C-side hub, so it crosses two latches. Each latch has its own enable. While the enable is low, the latch is transparent and its output follows its input without delay. While the enable is high, the latch presents the word it captured at the last clock edge on which its enable was low.

A port can have its own held word driven back onto it, for diagnostics. A control input flips bit 8 on words that come from port C, which lets software force parity errors. A readback whose latch is still open would form a loop. In that case the block raises a flag and drives the frozen held word.

Top module: `exch_top`

## Requirements
- R1: The source decode is as follows: `sel_hi`=1 picks port C; otherwise `sel_lo`=0 picks A and `sel_lo`=1 picks B. With all latch enables low, the A or B word appears on `c_dout` in the same cycle, chosen by `sel_lo`.
- R2: With all latch enables low, the source word reaches A and B in the same cycle. This covers C to A, C to B, C to both, B to A, B to A and C, and A to B. A word moving between A and B is never altered.
- R3: Enable polarities: `a_oe` follows the inverse of `oe_a_n`, `b_oe` follows `oe_b`, and `c_oe` follows the inverse of `oe_c_n`. The one exception is R7. With `oe_a_n`=1, `oe_b`=0 and `oe_c_n`=1, no port drives.
- R4: Each latch updates its held word at a rising clock edge only while its enable is low. While its enable is high, its output shows that held word and ignores input changes.
- R5: When `par_flip`=1, bit 8 of a word coming from port C is inverted on its way to A or B, and bits 7:0 pass unchanged. When `par_flip`=0, the word passes unchanged. Words whose source is A or B are never inverted.
- R6: Readback on A (A is the source, `oe_a_n`=0) drives the held C-to-A word onto `a_dout`. Readback on B (B is the source, `oe_b`=1) drives the held C-to-B word onto `b_dout`. Transfers to the other ports carry on unchanged.
- R7: Readback on C (C is the source, `oe_c_n`=0) drives the held A-to-C word when `sel_lo`=0, or the held B-to-C word when `sel_lo`=1. The port on that path, A or B respectively, has its output enable forced low.
- R8: A readback whose latch enable is low raises `loop_err` in the same cycle. The port then drives the word held before the loop began, and that latch does not update while the loop lasts.
- R9: Reset clears all four held words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the held words |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_lo | input | 1 | Low select bit (A or B when `sel_hi`=0) |
| sel_hi | input | 1 | High select bit (1 = C is the source) |
| oe_a_n | input | 1 | Port A output enable, active low |
| oe_b | input | 1 | Port B output enable, active high |
| oe_c_n | input | 1 | Port C output enable, active low |
| hold_ac | input | 1 | A-to-C latch enable (1 = hold) |
| hold_bc | input | 1 | B-to-C latch enable (1 = hold) |
| hold_ca | input | 1 | C-to-A latch enable (1 = hold) |
| hold_cb | input | 1 | C-to-B latch enable (1 = hold) |
| par_flip | input | 1 | Invert bit 8 on words from C |
| a_din | input | 9 | Port A pad input |
| a_dout | output | 9 | Port A pad output |
| a_oe | output | 1 | Port A pad output enable |
| b_din | input | 9 | Port B pad input |
| b_dout | output | 9 | Port B pad output |
| b_oe | output | 1 | Port B pad output enable |
| c_din | input | 9 | Port C pad input |
| c_dout | output | 9 | Port C pad output |
| c_oe | output | 1 | Port C pad output enable |
| loop_err | output | 1 | Readback attempted through an open latch |

## Verification
A held word that is corrupted stays hidden until a path is opened that shows it. The next readback or hold-mode transfer through that latch then shows the wrong value on the destination port in the same cycle. A latch that captures while its enable is high shows up one edge later, as a changed output during a hold. A wrong decode of the source or the readback shows up at once in the pad enables, or as a missing or spurious `loop_err`.

// File: rtl/exch_pkg.sv
package exch_pkg;
  parameter int WORD_W = 9;
  parameter int N_LAT  = 4;

  // direction latch indices
  localparam int L_AC = 0;
  localparam int L_BC = 1;
  localparam int L_CA = 2;
  localparam int L_CB = 3;

  typedef enum logic [1:0] {SRC_A = 2'd0, SRC_B = 2'd1, SRC_C = 2'd2} src_e;

  function automatic src_e src_decode(input logic hi, input logic lo);
    if (hi) return SRC_C;
    return lo ? SRC_B : SRC_A;
  endfunction
endpackage

// File: rtl/exch_latch.sv
module exch_latch #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         frz,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q <= '0;
    else if (!hold && !frz)  q <= d;
  end

  assign o = hold ? q : d;
endmodule

// File: rtl/exch_ctl.sv
module exch_ctl
  import exch_pkg::*;
(
  input  logic             sel_lo,
  input  logic             sel_hi,
  input  logic             oe_a_n,
  input  logic             oe_b,
  input  logic             oe_c_n,
  input  logic [N_LAT-1:0] hold_v,
  output src_e             src,
  output logic             rb_a,
  output logic             rb_b,
  output logic             rb_c,
  output logic [N_LAT-1:0] frz_v,
  output logic             loop_err,
  output logic             a_oe,
  output logic             b_oe,
  output logic             c_oe
);
  logic c_via_b;
  logic loop_a, loop_b, loop_c;

  assign src     = src_decode(sel_hi, sel_lo);
  assign c_via_b = sel_lo;

  assign rb_a = (src == SRC_A) && !oe_a_n;
  assign rb_b = (src == SRC_B) &&  oe_b;
  assign rb_c = (src == SRC_C) && !oe_c_n;

  assign loop_a = rb_a && !hold_v[L_CA];
  assign loop_b = rb_b && !hold_v[L_CB];
  assign loop_c = rb_c && !(c_via_b ? hold_v[L_BC] : hold_v[L_AC]);

  always_comb begin
    frz_v       = '0;
    frz_v[L_CA] = loop_a;
    frz_v[L_CB] = loop_b;
    frz_v[L_AC] = loop_c && !c_via_b;
    frz_v[L_BC] = loop_c &&  c_via_b;
  end

  assign loop_err = loop_a || loop_b || loop_c;

  assign a_oe = !oe_a_n && !(rb_c && !c_via_b);
  assign b_oe =  oe_b   && !(rb_c &&  c_via_b);
  assign c_oe = !oe_c_n;
endmodule

// File: rtl/exch_top.sv
module exch_top
  import exch_pkg::*;
#(
  parameter int W = exch_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_lo,
  input  logic         sel_hi,
  input  logic         oe_a_n,
  input  logic         oe_b,
  input  logic         oe_c_n,
  input  logic         hold_ac,
  input  logic         hold_bc,
  input  logic         hold_ca,
  input  logic         hold_cb,
  input  logic         par_flip,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         a_oe,
  input  logic [W-1:0] b_din,
  output logic [W-1:0] b_dout,
  output logic         b_oe,
  input  logic [W-1:0] c_din,
  output logic [W-1:0] c_dout,
  output logic         c_oe,
  output logic         loop_err
);
  localparam int TOP = W - 1;

  function automatic logic [W-1:0] flip_top(input logic [W-1:0] v, input logic inv);
    logic [W-1:0] r;
    r      = v;
    r[TOP] = v[TOP] ^ inv;
    return r;
  endfunction

  src_e             src;
  logic             rb_a, rb_b, rb_c;
  logic [N_LAT-1:0] hold_v, frz_v;
  logic [W-1:0]     lat_d [N_LAT];
  logic [W-1:0]     lat_q [N_LAT];
  logic [W-1:0]     lat_o [N_LAT];
  logic [W-1:0]     hub;

  always_comb begin
    hold_v       = '0;
    hold_v[L_AC] = hold_ac;
    hold_v[L_BC] = hold_bc;
    hold_v[L_CA] = hold_ca;
    hold_v[L_CB] = hold_cb;
  end

  exch_ctl u_ctl (
    .sel_lo  (sel_lo),
    .sel_hi  (sel_hi),
    .oe_a_n  (oe_a_n),
    .oe_b    (oe_b),
    .oe_c_n  (oe_c_n),
    .hold_v  (hold_v),
    .src     (src),
    .rb_a    (rb_a),
    .rb_b    (rb_b),
    .rb_c    (rb_c),
    .frz_v   (frz_v),
    .loop_err(loop_err),
    .a_oe    (a_oe),
    .b_oe    (b_oe),
    .c_oe    (c_oe)
  );

  // C-side hub: the word heading toward A and B
  always_comb begin
    case (src)
      SRC_C:   hub = flip_top(c_din, par_flip);
      SRC_B:   hub = lat_o[L_BC];
      default: hub = lat_o[L_AC];
    endcase
  end

  always_comb begin
    lat_d[L_AC] = a_din;
    lat_d[L_BC] = b_din;
    lat_d[L_CA] = hub;
    lat_d[L_CB] = hub;
  end

  for (genvar g = 0; g < N_LAT; g++) begin : g_lat
    exch_latch #(.W(W)) u_lat (
      .clk  (clk),
      .rst_n(rst_n),
      .hold (hold_v[g]),
      .frz  (frz_v[g]),
      .d    (lat_d[g]),
      .q    (lat_q[g]),
      .o    (lat_o[g])
    );
  end

  assign a_dout = rb_a ? lat_q[L_CA] : lat_o[L_CA];
  assign b_dout = rb_b ? lat_q[L_CB] : lat_o[L_CB];
  assign c_dout = rb_c ? (sel_lo ? lat_q[L_BC] : lat_q[L_AC])
                       : (sel_lo ? lat_o[L_BC] : lat_o[L_AC]);
endmodule

// File: rtl/exch_chk.sv
module exch_chk #(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel_lo,
  input logic         sel_hi,
  input logic         oe_a_n,
  input logic         oe_b,
  input logic         oe_c_n,
  input logic         hold_ac,
  input logic         hold_ca,
  input logic         par_flip,
  input logic [W-1:0] a_din,
  input logic [W-1:0] c_din,
  input logic [W-1:0] a_dout,
  input logic [W-1:0] c_dout,
  input logic         a_oe,
  input logic         loop_err
);
  logic src_a_now;
  assign src_a_now = !sel_hi && !sel_lo;

  // R1
  a_to_c_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_now && !hold_ac && oe_c_n) |-> (c_dout == a_din));

  // R4
  a_to_c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_now && oe_c_n && hold_ac && $past(hold_ac) && $past(src_a_now)
     && $past(oe_c_n) && $past(rst_n)) |-> $stable(c_dout));

  // R5
  c_to_a_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi && !hold_ca) |->
      (a_dout == {c_din[W-1] ^ par_flip, c_din[W-2:0]}));

  // R7
  c_readback_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi && !sel_lo && !oe_c_n) |-> !a_oe);

  // R8
  a_loop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_now && !oe_a_n && !hold_ca) |-> loop_err);
endmodule

bind exch_top exch_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel_lo  (sel_lo),
  .sel_hi  (sel_hi),
  .oe_a_n  (oe_a_n),
  .oe_b    (oe_b),
  .oe_c_n  (oe_c_n),
  .hold_ac (hold_ac),
  .hold_ca (hold_ca),
  .par_flip(par_flip),
  .a_din   (a_din),
  .c_din   (c_din),
  .a_dout  (a_dout),
  .c_dout  (c_dout),
  .a_oe    (a_oe),
  .loop_err(loop_err)
);

// File: tb/sim_exch_top.sv
module sim_exch_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_lo = 0, sel_hi = 0, oe_a_n = 1, oe_b = 0, oe_c_n = 1;
  logic hold_ac = 1, hold_bc = 1, hold_ca = 1, hold_cb = 1, par_flip = 0;
  logic [8:0] a_din = '0, b_din = '0, c_din = '0;
  logic [8:0] a_dout, b_dout, c_dout;
  logic a_oe, b_oe, c_oe, loop_err;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  exch_top u0 (
    .clk(clk), .rst_n(rst_n), .sel_lo(sel_lo), .sel_hi(sel_hi),
    .oe_a_n(oe_a_n), .oe_b(oe_b), .oe_c_n(oe_c_n),
    .hold_ac(hold_ac), .hold_bc(hold_bc), .hold_ca(hold_ca), .hold_cb(hold_cb),
    .par_flip(par_flip),
    .a_din(a_din), .a_dout(a_dout), .a_oe(a_oe),
    .b_din(b_din), .b_dout(b_dout), .b_oe(b_oe),
    .c_din(c_din), .c_dout(c_dout), .c_oe(c_oe),
    .loop_err(loop_err)
  );

  typedef struct packed {
    logic       hi, lo, oan, ob, ocn, pf;
    logic [8:0] a, b, c;
    logic       ea, eb, ec;
    logic [8:0] xa, xb, xc;
  } vec_t;

  // all latches transparent; data checked only where the port drives
  localparam vec_t TBL [9] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 9'h1A5,9'h000,9'h000, 1'b0,1'b0,1'b1, 9'h000,9'h000,9'h1A5}, // R1 A->C
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 9'h0F3,9'h000,9'h000, 1'b0,1'b1,1'b0, 9'h000,9'h0F3,9'h000}, // R2 A->B
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 9'h000,9'h155,9'h000, 1'b1,1'b0,1'b0, 9'h155,9'h000,9'h000}, // R2 B->A
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 9'h000,9'h0AA,9'h000, 1'b0,1'b0,1'b1, 9'h000,9'h000,9'h0AA}, // R1 B->C
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 9'h000,9'h000,9'h1C3, 1'b1,1'b0,1'b0, 9'h1C3,9'h000,9'h000}, // R2 C->A
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 9'h000,9'h000,9'h1C3, 1'b0,1'b1,1'b0, 9'h000,9'h0C3,9'h000}, // R5 C->B flip
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 9'h000,9'h000,9'h03C, 1'b1,1'b1,1'b0, 9'h13C,9'h13C,9'h000}, // R5 C->A+B flip
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 9'h000,9'h1FF,9'h000, 1'b1,1'b0,1'b1, 9'h1FF,9'h000,9'h1FF}, // R5 B->A+C no flip
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 9'h000,9'h000,9'h000, 1'b0,1'b0,1'b0, 9'h000,9'h000,9'h000}  // R3 all off
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_ctl(input logic hi, input logic lo, input logic oan,
                         input logic ob, input logic ocn);
    sel_hi = hi; sel_lo = lo; oe_a_n = oan; oe_b = ob; oe_c_n = ocn;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: held words are zero after reset (all latches holding)
    set_ctl(1, 0, 0, 1, 1); c_din = 9'h1FF; #1;
    chk("R9 a_dout", a_dout, 9'h000);
    chk("R9 b_dout", b_dout, 9'h000);
    set_ctl(0, 0, 1, 0, 0); a_din = 9'h1FF; #1;
    chk("R9 c_dout", c_dout, 9'h000);

    // vector table, all latches transparent
    hold_ac = 0; hold_bc = 0; hold_ca = 0; hold_cb = 0;
    for (int i = 0; i < 9; i++) begin
      set_ctl(TBL[i].hi, TBL[i].lo, TBL[i].oan, TBL[i].ob, TBL[i].ocn);
      par_flip = TBL[i].pf; a_din = TBL[i].a; b_din = TBL[i].b; c_din = TBL[i].c;
      #1;
      chk("R3 a_oe", {8'd0, a_oe}, {8'd0, TBL[i].ea});
      chk("R3 b_oe", {8'd0, b_oe}, {8'd0, TBL[i].eb});
      chk("R3 c_oe", {8'd0, c_oe}, {8'd0, TBL[i].ec});
      if (TBL[i].ea) chk("R2 a_dout", a_dout, TBL[i].xa);
      if (TBL[i].eb) chk("R2 b_dout", b_dout, TBL[i].xb);
      if (TBL[i].ec) chk("R1 c_dout", c_dout, TBL[i].xc);
      edge_step();
    end
    par_flip = 0;

    // R4: hold keeps the word captured at the last edge with enable low
    set_ctl(0, 0, 1, 0, 0); hold_ac = 0; a_din = 9'h123;
    edge_step();
    hold_ac = 1; a_din = 9'h0FE; #1;
    chk("R4 hold same cycle", c_dout, 9'h123);
    edge_step(); edge_step();
    chk("R4 hold after edges", c_dout, 9'h123);

    // R6: readback on A after latching a word from C
    set_ctl(1, 0, 1, 0, 1); hold_ca = 0; c_din = 9'h0B7;
    edge_step();
    hold_ca = 1; hold_ac = 0;
    set_ctl(0, 0, 0, 0, 0); a_din = 9'h044; #1;
    chk("R6 a readback", a_dout, 9'h0B7);
    chk("R6 a_oe", {8'd0, a_oe}, 9'd1);
    chk("R6 c unaffected", c_dout, 9'h044);
    chk("R8 no loop", {8'd0, loop_err}, 9'd0);
    edge_step();

    // R6: readback on B, held word was flipped on entry from C
    set_ctl(1, 0, 1, 0, 1); par_flip = 1; hold_cb = 0; c_din = 9'h16D;
    edge_step();
    hold_cb = 1; par_flip = 0; hold_bc = 0; hold_ca = 0;
    set_ctl(0, 1, 0, 1, 1); b_din = 9'h121; #1;
    chk("R6 b readback", b_dout, 9'h06D);
    chk("R6 a unaffected", a_dout, 9'h121);
    edge_step();

    // R7: readback on C through the A path, A cut off
    set_ctl(0, 0, 1, 0, 1); hold_ac = 0; a_din = 9'h0D2;
    edge_step();
    hold_ac = 1; hold_cb = 0;
    set_ctl(1, 0, 0, 1, 0); c_din = 9'h011; #1;
    chk("R7 c readback via A", c_dout, 9'h0D2);
    chk("R7 a cut", {8'd0, a_oe}, 9'd0);
    chk("R7 b still fed", b_dout, 9'h011);
    chk("R7 b_oe", {8'd0, b_oe}, 9'd1);
    edge_step();

    // R7: readback on C through the B path, B cut off
    set_ctl(0, 1, 1, 0, 1); hold_bc = 0; b_din = 9'h1E1;
    edge_step();
    hold_bc = 1;
    set_ctl(1, 1, 0, 1, 0); #1;
    chk("R7 c readback via B", c_dout, 9'h1E1);
    chk("R7 b cut", {8'd0, b_oe}, 9'd0);
    chk("R7 a_oe kept", {8'd0, a_oe}, 9'd1);
    edge_step();

    // R8: readback through an open latch flags and freezes
    set_ctl(1, 0, 1, 0, 1); hold_ca = 0; c_din = 9'h0E0;
    edge_step();
    set_ctl(0, 0, 0, 0, 1); hold_ac = 0; a_din = 9'h1AB; #1;
    chk("R8 loop flag", {8'd0, loop_err}, 9'd1);
    chk("R8 frozen word", a_dout, 9'h0E0);
    edge_step();
    a_din = 9'h055; edge_step();
    chk("R8 still frozen", a_dout, 9'h0E0);
    oe_a_n = 1; #1;
    chk("R8 flag clears", {8'd0, loop_err}, 9'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule